// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port with Clock Polarity Select

This block is an 8-bit full-duplex serial port for a processor. Software reaches it through three small registers: a data buffer, a control register and a status register. In master mode, a write to the data buffer starts an exchange immediately. The port generates eight clock pulses and shifts the buffer out, most significant bit first. At the same time it shifts the serial input into the same buffer, so that when the exchange ends the buffer holds the received byte. A completion flag then rises, drives the interrupt output, and stays set until software clears it.

A single polarity bit sets both the idle level of the clock and which edge does what. The edge that leaves the idle level always drives new output data. The edge that returns to the idle level always samples input data. With the bit at 1 the clock idles high, drives on falling edges and samples on rising edges. With the bit at 0 the clock idles low, drives on rising edges and samples on falling edges.

In slave mode the clock is an input from an external master, and an active-low select input qualifies the exchange. Both inputs, and the serial data input, pass through two-flop synchronizers before the port detects edges on the system clock.

The control state machine has five states:
- `ST_IDLE` goes to `ST_M_LEAD` on a master-mode buffer write, or to `ST_S_XFER` when slave mode sees the select input low.
- `ST_M_LEAD` goes to `ST_M_TRAIL` on a divider tick; this is the leading edge, where data is driven.
- `ST_M_TRAIL` goes back to `ST_M_LEAD` on a divider tick; this is the trailing edge, where data is sampled. After the eighth bit it goes to `ST_DONE` instead.
- `ST_S_XFER` goes to `ST_DONE` on the eighth synchronized trailing edge, or back to `ST_IDLE` if the select input rises first.
- `ST_DONE` goes to `ST_IDLE` after one cycle.

Clearing the enable bit forces `ST_IDLE` from any state.

Top module: `spi_port`

## Requirements
- R1: Register map by `reg_addr`: 0 is the data buffer, 1 is control, 2 is status. A write to address 0 while enabled, in master mode and idle, starts an exchange, and status bit 2 (busy) reads 1 from the next cycle.
- R2: A master exchange drives exactly 8 clock pulses. The interval between leading edges is 4, 16 or 64 system clocks for control rate field values 0, 1 and 2 or 3.
- R3: Bit 7 of the buffer is the first bit to appear on `sdo_o`, followed by the lower bits in order.
- R4: Each trailing edge shifts the serial input into bit 0 of the buffer, so after an exchange, address 0 reads the received byte.
- R5: Control bit 2 is the polarity. While idle in master mode, `sck_o` equals it. `sdo_o` changes only on leading edges, which move the clock away from that level.
- R6: Status bit 0 is set when an exchange completes, and `irq` follows it. It stays set until a write to address 2 with data bit 0 at 1.
- R7: A write to address 0 while busy leaves the buffer unchanged and sets status bit 1. That bit stays set until a write to address 2 with data bit 1 at 1.
- R8: With control bit 1 set (slave mode), `sck_oe` is 0. The exchange is clocked by `sck_i` while `ss_n_i` is low, with the same polarity and edge rules, MSB-first output and completion flag.
- R9: In slave mode, if `ss_n_i` rises before the eighth trailing edge, the exchange aborts, busy clears and status bit 0 stays 0.
- R10: Control bit 0 is the enable. After reset all registers read 0. While disabled, a write to address 0 loads the buffer but starts nothing and the clock stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Completion interrupt, mirrors status bit 0 |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | High when the port drives the serial clock |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low slave select |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The in-module assertions check these properties on every cycle:
- the busy state begins right after a master start (R1);
- the clock rests at the polarity level while idle (R5);
- the completion flag falls only on a clearing status write (R6);
- a write while busy raises the collision bit (R7);
- slave mode never drives the clock (R8);
- a released select ends a slave exchange (R9).

Only the bench scenarios can show the end-to-end properties: the exact pulse count and edge spacing for each rate code, MSB-first ordering, whether sampling falls on the trailing rather than the leading edge, and the received byte landing in the buffer. The bench sweeps both polarities, all rate codes and several byte patterns in master mode, and both polarities in slave mode.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LEAD,
        ST_M_TRAIL,
        ST_S_XFER,
        ST_DONE
    } xfer_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic [1:0] rate;
        logic       cpol;
        logic       slave;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int DIV0 = 4,
    parameter int DIV1 = 16,
    parameter int DIV2 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int HMAX = DIV2 / 2;
    localparam int CW   = $clog2(HMAX) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half;

    always_comb begin
        unique case (rate)
            2'd0:    half = CW'(DIV0 / 2);
            2'd1:    half = CW'(DIV1 / 2);
            default: half = CW'(DIV2 / 2);
        endcase
    end

    assign tick = run && (cnt_q >= half - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + CW'(1);
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(tick)) |-> !tick || half == CW'(1));

endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int             W   = 3,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST[i];
                s2_q <= RST[i];
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV0   = 4,
    parameter int DIV1   = 16,
    parameter int DIV2   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    input  logic              ss_n_i,
    output logic              sdo_o,
    input  logic              sdi_i
);
    localparam int BCW = $clog2(DATA_W);

    xfer_state_t state_q, state_d;
    ctrl_t       ctrl_q;
    logic [DATA_W-1:0] buf_q;
    logic [BCW-1:0]    bitcnt_q;
    logic phase_q, sdo_q, done_q, wcol_q;

    logic tick, busy, last_bit;
    logic data_wr, ctrl_wr, stat_wr;
    logic lead_ev, trail_ev;

    // synchronized slave inputs: {sdi, ss_n, sck}
    logic [2:0] sync_q;
    logic       sck_s, ss_s, sdi_s, sck_prev_q;
    logic       s_lead, s_trail;

    spi_sync #(.W(3), .RST(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sdi_i, ss_n_i, sck_i}),
        .q    (sync_q)
    );
    assign sck_s = sync_q[0];
    assign ss_s  = sync_q[1];
    assign sdi_s = sync_q[2];

    spi_rate_div #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_M_LEAD || state_q == ST_M_TRAIL),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    assign data_wr  = reg_wr && reg_addr == ADDR_DATA;
    assign ctrl_wr  = reg_wr && reg_addr == ADDR_CTRL;
    assign stat_wr  = reg_wr && reg_addr == ADDR_STAT;
    assign busy     = state_q != ST_IDLE;
    assign last_bit = bitcnt_q == BCW'(DATA_W - 1);

    assign s_lead  = (sck_s != sck_prev_q) && (sck_s != ctrl_q.cpol);
    assign s_trail = (sck_s != sck_prev_q) && (sck_s == ctrl_q.cpol);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-cycle events
    always_comb begin
        state_d  = state_q;
        lead_ev  = 1'b0;
        trail_ev = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_q.en && !ctrl_q.slave && data_wr) state_d = ST_M_LEAD;
                else if (ctrl_q.en && ctrl_q.slave && !ss_s) state_d = ST_S_XFER;
            end
            ST_M_LEAD: begin
                if (tick) begin
                    lead_ev = 1'b1;
                    state_d = ST_M_TRAIL;
                end
            end
            ST_M_TRAIL: begin
                if (tick) begin
                    trail_ev = 1'b1;
                    state_d  = last_bit ? ST_DONE : ST_M_LEAD;
                end
            end
            ST_S_XFER: begin
                if (ss_s) begin
                    state_d = ST_IDLE;
                end else if (s_lead) begin
                    lead_ev = 1'b1;
                end else if (s_trail) begin
                    trail_ev = 1'b1;
                    if (last_bit) state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!ctrl_q.en) state_d = ST_IDLE;
    end

    // datapath and software-visible state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            buf_q      <= '0;
            bitcnt_q   <= '0;
            phase_q    <= 1'b0;
            sdo_q      <= 1'b0;
            done_q     <= 1'b0;
            wcol_q     <= 1'b0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);

            if (data_wr && !busy)
                buf_q <= reg_wdata;
            else if (trail_ev)
                buf_q <= {buf_q[DATA_W-2:0], ctrl_q.slave ? sdi_s : sdi_i};

            if (state_q == ST_IDLE) bitcnt_q <= '0;
            else if (trail_ev)      bitcnt_q <= bitcnt_q + BCW'(1);

            if (lead_ev)                                phase_q <= 1'b1;
            else if (trail_ev || state_q == ST_IDLE)    phase_q <= 1'b0;

            if (lead_ev) sdo_q <= buf_q[DATA_W-1];

            if (state_q == ST_DONE)             done_q <= 1'b1;
            else if (stat_wr && reg_wdata[0])   done_q <= 1'b0;

            if (data_wr && busy)                wcol_q <= 1'b1;
            else if (stat_wr && reg_wdata[1])   wcol_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sck_oe = ctrl_q.en && !ctrl_q.slave;
        sck_o  = sck_oe ? (ctrl_q.cpol ^ phase_q) : ctrl_q.cpol;
        sdo_o  = sdo_q;
        irq    = done_q;
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = buf_q;
            ADDR_CTRL: reg_rdata = DATA_W'(ctrl_q);
            ADDR_STAT: reg_rdata = DATA_W'({busy, wcol_q, done_q});
            default:   reg_rdata = '0;
        endcase
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl_q.en && !ctrl_q.slave && data_wr && !ctrl_wr)
        |=> reg_addr != ADDR_STAT || reg_rdata[2]);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl_q.en && !ctrl_q.slave) |-> sck_o == ctrl_q.cpol);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_wr && reg_wdata[0]));

    // R7
    collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_wr) |=> wcol_q && $stable(buf_q) || $past(trail_ev));

    // R8
    slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.slave |-> !sck_oe);

    // R9
    select_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S_XFER && ss_s) |=> state_q == ST_IDLE && !$rose(irq));

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq, sck_o, sck_oe, sdo_o;
    logic sck_i = 1'b0, ss_n_i = 1'b1, sdi_i = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .ss_n_i(ss_n_i),
        .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic master_xfer(input logic pol, input logic [1:0] rt,
                               input logic [7:0] tx, input logic [7:0] rx, input bit collide);
        int d = (rt == 2'd0) ? 4 : (rt == 2'd1) ? 16 : 64;
        int leads = 0, trails = 0, first = -1, last = -1, cyc = 0;
        logic [7:0] got = '0;
        logic [7:0] rb;
        logic prev_sck, prev_sdo;
        bit bad_edge = 0, did = 0;
        reg_write(A_CTRL, {3'b000, rt, pol, 1'b0, 1'b1});
        reg_write(A_STAT, 8'h03);
        // R5 idle level
        check(sck_o == pol, "R5 idle level", sck_o, pol);
        reg_write(A_DATA, tx);
        reg_addr = A_STAT;
        #1;
        // R1 busy right after start
        check(reg_rdata[2] == 1'b1, "R1 busy after start", reg_rdata[2], 1);
        prev_sck = sck_o; prev_sdo = sdo_o;
        while (!reg_rdata[0] && cyc < 4000) begin
            @(negedge clk); cyc++;
            if (sck_o != prev_sck) begin
                if (sck_o != pol) begin
                    leads++;
                    if (first < 0) first = cyc;
                    last = cyc;
                    if (leads <= 8) sdi_i = rx[8 - leads];
                end else begin
                    trails++;
                    got = {got[6:0], sdo_o};
                end
            end
            if (sdo_o != prev_sdo && sck_o == pol) bad_edge = 1;
            prev_sck = sck_o; prev_sdo = sdo_o;
            if (collide && leads == 3 && !did) begin
                did = 1;
                reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 8'hEE;
                @(negedge clk); cyc++;
                reg_wr = 1'b0; reg_addr = A_STAT;
            end
            #1;
        end
        check(leads == 8 && trails == 8, "R2 pulse count", leads, 8);
        check(last - first == 7 * d, "R2 edge spacing", last - first, 7 * d);
        check(got == tx, "R3 msb-first output", got, tx);
        check(!bad_edge, "R5 drive edge", bad_edge, 0);
        check(irq == 1'b1, "R6 irq at completion", irq, 1);
        reg_read(A_DATA, rb);
        check(rb == rx, "R4 received byte", rb, rx);
        if (collide) begin
            reg_read(A_STAT, rb);
            check(rb[1] == 1'b1, "R7 collision sticky", rb[1], 1);
            reg_write(A_STAT, 8'h02);
            reg_read(A_STAT, rb);
            check(rb[1] == 1'b0 && rb[0] == 1'b1, "R7 collision clear", rb, 8'h01);
        end
    endtask

    task automatic slave_xfer(input logic pol, input logic [7:0] tx,
                              input logic [7:0] rx, input bit abort);
        int nb = abort ? 3 : 8;
        logic [7:0] got = '0;
        logic [7:0] rb;
        ss_n_i = 1'b1;
        sck_i = pol;
        reg_write(A_CTRL, {3'b000, 2'b00, pol, 1'b1, 1'b1});
        reg_write(A_STAT, 8'h03);
        reg_write(A_DATA, tx);
        repeat (4) @(negedge clk);
        check(sck_oe == 1'b0, "R8 clock not driven", sck_oe, 0);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            sck_i = ~pol; sdi_i = rx[7 - b];
            repeat (8) @(negedge clk);
            got = {got[6:0], sdo_o};
            sck_i = pol;
            repeat (8) @(negedge clk);
        end
        if (!abort) begin
            check(irq == 1'b1, "R8 slave completion", irq, 1);
            check(got == tx, "R8 slave msb-first", got, tx);
            reg_read(A_DATA, rb);
            check(rb == rx, "R8 slave received", rb, rx);
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
        end else begin
            ss_n_i = 1'b1;
            repeat (10) @(negedge clk);
            reg_read(A_STAT, rb);
            check(rb[2] == 1'b0, "R9 abort clears busy", rb[2], 0);
            check(rb[0] == 1'b0 && irq == 1'b0, "R9 abort no flag", rb[0], 0);
        end
    endtask

    initial begin
        logic [7:0] rb;
        logic [7:0] pats [3] = '{8'hA5, 8'h00, 8'h3C};
        logic [7:0] rpat [3] = '{8'h5A, 8'hFF, 8'hC1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        reg_read(A_DATA, rb); check(rb == 8'h00, "R10 reset data", rb, 0);
        reg_read(A_CTRL, rb); check(rb == 8'h00, "R10 reset ctrl", rb, 0);
        reg_read(A_STAT, rb); check(rb == 8'h00, "R10 reset status", rb, 0);
        check(irq == 1'b0 && sck_oe == 1'b0, "R10 reset outputs", {irq, sck_oe}, 0);
        // R10 disabled write loads but does not start
        reg_write(A_DATA, 8'h5A);
        begin
            bit moved = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (sck_o != 1'b0) moved = 1;
            end
            check(!moved, "R10 disabled clock idle", moved, 0);
        end
        reg_read(A_STAT, rb); check(rb[2] == 1'b0, "R10 disabled not busy", rb[2], 0);
        reg_read(A_DATA, rb); check(rb == 8'h5A, "R10 disabled load", rb, 8'h5A);

        // master sweep over polarity, rate code and pattern
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 4; r++)
                for (int k = 0; k < 3; k++)
                    master_xfer(p[0], r[1:0], pats[k] ^ 8'(r * 17), rpat[k] ^ 8'(p * 9), 1'b0);

        // R6 flag persists until cleared by a 1 in bit 0
        repeat (50) @(negedge clk);
        check(irq == 1'b1, "R6 flag holds", irq, 1);
        reg_write(A_STAT, 8'h00);
        check(irq == 1'b1, "R6 zero write keeps flag", irq, 1);
        reg_write(A_STAT, 8'h01);
        check(irq == 1'b0, "R6 flag cleared", irq, 0);

        // R7 write collision during a transfer
        master_xfer(1'b0, 2'd1, 8'h96, 8'h2B, 1'b1);
        master_xfer(1'b1, 2'd1, 8'h0F, 8'hD4, 1'b1);

        // slave mode, both polarities
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 3; k++)
                slave_xfer(p[0], pats[k], rpat[k], 1'b0);
        slave_xfer(1'b0, 8'h81, 8'h7E, 1'b1);
        slave_xfer(1'b1, 8'h42, 8'h24, 1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule